// File: doc/BRIEF.md
# Two-Speed Angle Read Latch

This block sits between a continuously updating two-speed angle converter and a host read port. The converter core presents a combined coarse/fine angle of up to 24 bits and a separate 16-bit coarse-only angle. The host sees four read views: the coarse angle, an upper angle word, a lower angle word and a 32-bit combined view. Because the core keeps changing the angle between two host reads, a read of the lower word also captures the upper word in the same cycle. A later upper-word read then returns a value that belongs with that lower word, however long the host waits in between.

The number of valid angle bits follows a configured speed ratio of 2^k. The resolution is 16+k bits for k = 0..8, so a ratio of 256 gives 24 bits. Bits below the active resolution read as zero in the lower word and in the combined view. Changing the ratio discards any pending capture.

Top module: `angle_read_latch`

## Requirements
- R1: A read with `rd_en` high is sampled on a rising edge and answered on that same edge: `rd_valid` is high for exactly one cycle and `rd_data` holds the answer. With no read, `rd_valid` is low and `rd_data` keeps its value. After reset `rd_valid` is 0, `rd_data` is 0 and no capture is held.
- R2: A lower-word read captures `fine_angle[23:8]`. Every later upper-word read returns that captured value, whatever the angle does, until the next lower-word read or a ratio change.
- R3: A lower-word read returns `fine_angle[7:0]` in `rd_data[15:8]`, with zeros in `rd_data[7:0]` and `rd_data[31:16]`. Angle bits below the active resolution read as zero, so with k = 0 the whole word is zero.
- R4: The effective exponent k is `ratio_exp` clamped to 8, so inputs 9..15 behave as 8. The resolution is 16+k bits and keeps angle bits 23 down to 8-k.
- R5: A combined read returns the masked 24-bit angle in `rd_data[31:8]` and zeros in `rd_data[7:0]`. All of it is taken from the angle present in the read cycle.
- R6: A coarse read returns `{16'h0, coarse_angle}` and does not touch the capture.
- R7: An upper-word read while no capture is held returns the live `fine_angle[23:8]`. Upper-word reads are never masked.
- R8: When the effective k differs from its value in the previous cycle, any capture is dropped. If a lower-word read falls in that same cycle, the new capture is kept.
- R9: The `rd_sel` encoding is 0 = coarse, 1 = upper word, 2 = lower word, 3 = combined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fine_angle | input | 24 | Combined coarse/fine angle from the converter core |
| coarse_angle | input | 16 | Coarse-only angle from the converter core |
| ratio_exp | input | 4 | Speed ratio exponent k (ratio 2^k) |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 2 | Read view select |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid for one cycle |

## Verification
The collision that matters is a lower-word read landing in the same cycle as a change of ratio: one event drops the capture and the other sets it. The bench provokes this directly by changing `ratio_exp` on the cycle of a lower-word read. It judges the outcome by the next upper-word read, which must return the freshly captured word rather than the live angle. Random runs change the ratio at random points among mixed reads, and a bench-side model decides in each cycle whether a capture is held.

// File: rtl/alr_pkg.sv
package alr_pkg;
  typedef enum logic [1:0] {
    SEL_COARSE = 2'd0,
    SEL_HIGH   = 2'd1,
    SEL_LOW    = 2'd2,
    SEL_COMB   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/alr_ratio.sv
module alr_ratio #(
  parameter int ANG_W  = 24,
  parameter int FRAC_W = 8,
  parameter int MAX_K  = 8,
  parameter int KW     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KW-1:0]    k_in,
  output logic [KW-1:0]    k_eff,
  output logic             ratio_chg,
  output logic [ANG_W-1:0] mask
);
  logic [KW-1:0] k_q;

  assign k_eff     = (k_in > KW'(MAX_K)) ? KW'(MAX_K) : k_in;
  assign ratio_chg = (k_eff != k_q);

  always_ff @(posedge clk) begin
    if (rst) k_q <= '0;
    else     k_q <= k_eff;
  end

  for (genvar i = 0; i < ANG_W; i++) begin : g_mask
    if (i >= FRAC_W) begin : g_full
      assign mask[i] = 1'b1;
    end else begin : g_frac
      localparam logic [KW-1:0] NEED = KW'(FRAC_W - i);
      assign mask[i] = (k_eff >= NEED);
    end
  end
endmodule

// File: rtl/alr_snap.sv
module alr_snap #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              clr,
  input  logic [WORD_W-1:0] hi_live,
  output logic [WORD_W-1:0] hi_out
);
  logic [WORD_W-1:0] snap_q;
  logic              snap_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      snap_v <= 1'b0;
    end else if (cap) begin
      snap_q <= hi_live;
      snap_v <= 1'b1;
    end else if (clr) begin
      snap_v <= 1'b0;
    end
  end

  assign hi_out = snap_v ? snap_q : hi_live;

  // R2: a held capture stays put until the next capture
  assert_snap_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (snap_v && !cap) |=> $stable(snap_q));

  // R8: a ratio change without a capture leaves nothing held
  assert_snap_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !cap) |=> !snap_v);
endmodule

// File: rtl/angle_read_latch.sv
module angle_read_latch #(
  parameter int ANG_W  = 24,
  parameter int WORD_W = 16,
  parameter int BUS_W  = 32,
  parameter int MAX_K  = 8,
  localparam int KW    = $clog2(MAX_K + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ANG_W-1:0]  fine_angle,
  input  logic [WORD_W-1:0] coarse_angle,
  input  logic [KW-1:0]     ratio_exp,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid
);
  import alr_pkg::*;

  localparam int FRAC_W = ANG_W - WORD_W;
  localparam int LO_SH  = WORD_W - FRAC_W;
  localparam int CB_SH  = BUS_W - ANG_W;

  logic [KW-1:0]     k_eff;
  logic              ratio_chg;
  logic [ANG_W-1:0]  mask;
  logic [ANG_W-1:0]  angle_m;
  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] lo_word;
  logic [BUS_W-1:0]  comb_word;
  logic [BUS_W-1:0]  next_data;
  logic              take_snap;
  rd_sel_e           sel;

  assign sel = rd_sel_e'(rd_sel);

  alr_ratio #(.ANG_W(ANG_W), .FRAC_W(FRAC_W), .MAX_K(MAX_K), .KW(KW)) u_ratio (
    .clk(clk), .rst(rst), .k_in(ratio_exp),
    .k_eff(k_eff), .ratio_chg(ratio_chg), .mask(mask)
  );

  assign take_snap = rd_en && (sel == SEL_LOW);

  alr_snap #(.WORD_W(WORD_W)) u_snap (
    .clk(clk), .rst(rst), .cap(take_snap), .clr(ratio_chg),
    .hi_live(fine_angle[ANG_W-1:FRAC_W]), .hi_out(hi_word)
  );

  assign angle_m   = fine_angle & mask;
  assign lo_word   = WORD_W'(angle_m[FRAC_W-1:0]) << LO_SH;
  assign comb_word = BUS_W'(angle_m) << CB_SH;

  always_comb begin
    unique case (sel)
      SEL_COARSE: next_data = BUS_W'(coarse_angle);
      SEL_HIGH:   next_data = BUS_W'(hi_word);
      SEL_LOW:    next_data = BUS_W'(lo_word);
      default:    next_data = comb_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= next_data;
    end
  end

  // R1: one valid pulse per read strobe
  assert_valid_R1: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  // R3: at ratio 1 the lower word is all zero
  assert_lo_k0_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_LOW && k_eff == '0) |=> (rd_data == '0));

  // R5: combined view pads its low byte with zero
  assert_comb_pad_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_COMB) |=> (rd_data[CB_SH-1:0] == '0));

  // R6: coarse view passes the coarse angle through
  assert_coarse_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_COARSE) |=> (rd_data == BUS_W'($past(coarse_angle))));
endmodule

// File: tb/sim_angle_read_latch.sv
module sim_angle_read_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] fine_angle = '0;
  logic [15:0] coarse_angle = '0;
  logic [3:0]  ratio_exp = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] m_snap = '0;
  bit          m_sv = 1'b0;
  logic [3:0]  m_kq = '0;
  logic [31:0] m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  angle_read_latch u0 (
    .clk(clk), .rst(rst), .fine_angle(fine_angle), .coarse_angle(coarse_angle),
    .ratio_exp(ratio_exp), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [3:0] clamp_k(input logic [3:0] k);
    return (k > 4'd8) ? 4'd8 : k;
  endfunction

  function automatic logic [7:0] frac_of(input logic [23:0] a, input logic [3:0] k);
    logic [7:0] m;
    m = 8'hFF << (4'd8 - clamp_k(k));
    return a[7:0] & m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit en, input logic [1:0] sel, input logic [23:0] a,
                      input logic [15:0] c, input logic [3:0] k, input string tag);
    logic [3:0] kk;
    string t;
    rd_en = en; rd_sel = sel; fine_angle = a; coarse_angle = c; ratio_exp = k;
    @(posedge clk);
    kk = clamp_k(k);
    t = tag;
    if (en) begin
      case (sel)
        2'd0: begin m_data = {16'h0, c}; if (t == "") t = "R6"; end
        2'd1: begin m_data = {16'h0, (m_sv ? m_snap : a[23:8])};
                    if (t == "") t = m_sv ? "R2" : "R7"; end
        2'd2: begin m_data = {16'h0, frac_of(a, k), 8'h00}; if (t == "") t = "R3"; end
        default: begin m_data = {a[23:8], frac_of(a, k), 8'h00}; if (t == "") t = "R5"; end
      endcase
    end else if (t == "") t = "R1";
    if (en && sel == 2'd2) begin m_snap = a[23:8]; m_sv = 1'b1; end
    else if (kk != m_kq) m_sv = 1'b0;
    m_kq = kk;
    #1;
    check({t, " valid"}, {31'h0, rd_valid}, {31'h0, en});
    check({t, " data"}, rd_data, m_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {31'h0, rd_valid}, 32'h0);
    check("R1 reset data", rd_data, 32'h0);
    rst = 1'b0;

    step(1, 2'd1, 24'h123456, 16'h0001, 4'd8, "R7");
    step(1, 2'd2, 24'hABCDEF, 16'h0001, 4'd8, "R3");
    step(0, 2'd0, 24'h111111, 16'h0001, 4'd8, "R1");
    step(1, 2'd1, 24'h222222, 16'h0001, 4'd8, "R2");
    step(1, 2'd3, 24'h98765F, 16'h0001, 4'd8, "R5");
    step(1, 2'd0, 24'h333333, 16'h5A5A, 4'd8, "R9");
    step(1, 2'd1, 24'h444444, 16'h0001, 4'd8, "R6");
    // ratio change and lower-word read in the same cycle
    step(1, 2'd2, 24'hFFFFFF, 16'h0001, 4'd3, "R8");
    step(1, 2'd1, 24'h000000, 16'h0001, 4'd3, "R8");
    step(0, 2'd0, 24'h000000, 16'h0001, 4'd5, "R8");
    step(1, 2'd1, 24'h3C3C3C, 16'h0001, 4'd5, "R8");
    step(1, 2'd2, 24'hFFFFFF, 16'h0001, 4'd0, "R3");
    step(1, 2'd3, 24'hFFFFFF, 16'h0001, 4'd12, "R4");
    step(1, 2'd3, 24'hFFFFFF, 16'h0001, 4'd1, "R4");
    step(0, 2'd3, 24'hFFFFFF, 16'h0001, 4'd1, "R1");

    begin
      logic [3:0] k = 4'd8;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 7) == 0) k = 4'($urandom_range(0, 15));
        step(bit'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
             24'($urandom), 16'($urandom), k, "");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule